// File: doc/BRIEF.md
# Parallel DAC Bus Write Sequencer

This block sits on the host side of an eight-channel voltage DAC that has a level-triggered parallel interface. That interface has a chip select, a write strobe, a channel address, a data bus, four pair-load strobes and a clear strobe. The host hands the sequencer one request at a time through a valid/ready handshake. A request is one of four kinds:
- write a signed sample to one channel's input register;
- pulse any combination of the four pair-load strobes;
- pulse the clear strobe;
- write a sample and overlap a pair load with that write.

The sequencer turns each request into bus waveforms. It never violates the minimum pulse widths, the setup and hold times, or the rule that a load strobe which overlaps a write must outlast the write by a full load width. Every minimum is given on a configuration input as a count of system-clock cycles. A count of zero is rounded up to one cycle. Samples arrive in two's complement. They are converted to offset binary on the way to the bus by inverting the most significant bit. All bus outputs are registered and active low.

Top module: `dacseq_top`

## Requirements
- R1: In reset and directly after it, req_ready is 1, bus_cs_n, bus_wr_n and bus_clr_n are 1, and bus_ld_n is all ones.
- R2: A request is taken on a rising edge where req_valid and req_ready are both 1. req_ready is 0 from the next cycle until the sequence ends. The busy time is set by the request kind (req_kind: 0 write, 1 pair load, 2 clear, 3 write with load):
  - write: N+2 cycles;
  - pair load: L cycles;
  - clear: C cycles;
  - write with load: N+1+L cycles.
- R3: For a write, bus_addr carries req_chan and bus_data carries the converted sample. Both are valid for one cycle before the strobes fall. Both stay unchanged while the strobes are low and for at least one cycle after the strobes rise.
- R4: bus_cs_n and bus_wr_n fall and rise on the same edge. They stay low for N cycles, where N is the larger of the rounded write width and the rounded data setup count.
- R5: bus_data equals the request value plus 4096 modulo 8192, which is the value with bit 12 inverted. Examples: 0 gives 0x1000, 0x1FFF gives 0x0FFF, 0x0FFF gives 0x1FFF, and 0x1000 gives 0x0000.
- R6: A pair load drives bus_ld_n[i] low for L cycles for every bit i set in req_mask, where bit i serves channels 2i and 2i+1. Unmasked strobes stay high. A mask of zero drives no strobe.
- R7: A write with load drives the masked load strobes low on the same edge as the write strobe. Those strobes stay low for L cycles after the write strobe rises, for N+L cycles in total.
- R8: A clear drives bus_clr_n low for C cycles while chip select, write and all load strobes stay high.
- R9: Each configured count of zero is treated as one cycle, so N, L and C are never below 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_kind | input | 2 | 0 write, 1 pair load, 2 clear, 3 write with load |
| req_chan | input | 3 | Target channel for writes |
| req_value | input | 13 | Two's-complement sample |
| req_mask | input | 4 | Pair-load strobe selection |
| cfg_wr_cyc | input | 8 | Minimum chip select / write low time, cycles |
| cfg_setup_cyc | input | 8 | Minimum data valid time before write rises, cycles |
| cfg_ld_cyc | input | 8 | Minimum load low time, cycles |
| cfg_clr_cyc | input | 8 | Minimum clear low time, cycles |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_addr | output | 3 | Channel address |
| bus_data | output | 13 | Offset-binary data |
| bus_ld_n | output | 4 | Pair-load strobes, active low |
| bus_clr_n | output | 1 | Clear strobe, active low |

## Verification
Pair-load and clear strobes move on the acceptance edge itself. A write first spends one setup cycle on address and data, and its strobes fall on the next edge. The release of each strobe and the return of ready follow exactly N, L or C cycles later, as R2 gives them. The bench drives requests and samples on the falling edge. From the acceptance edge onward it counts, for each bus signal, the low cycles seen before ready returns. It compares each count with the value computed from the configured widths. It also checks address and data in the cycles before, during and just after the write strobe.

// File: rtl/dacseq_pkg.sv
package dacseq_pkg;

  typedef enum logic [1:0] {
    KIND_WRITE = 2'd0,
    KIND_LOAD  = 2'd1,
    KIND_CLEAR = 2'd2,
    KIND_WRLD  = 2'd3
  } req_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_TAIL,
    ST_LOAD,
    ST_CLEAR
  } seq_state_e;

endpackage

// File: rtl/dacseq_fmt.sv
module dacseq_fmt #(
  parameter int DW = 13
) (
  input  logic [DW-1:0] twos_i,
  output logic [DW-1:0] offs_o
);
  // Adding half of full scale modulo 2^DW flips the sign bit only.
  assign offs_o = {~twos_i[DW-1], twos_i[DW-2:0]};
endmodule

// File: rtl/dacseq_timer.sv
module dacseq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [CW-1:0] len_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  // A programmed length of zero still yields one cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= (len_i == '0) ? '0 : len_i - 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dacseq_top.sv
module dacseq_top #(
  parameter int DATA_W   = 13,
  parameter int CHANNELS = 8,
  parameter int CNT_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [1:0]                    req_kind,
  input  logic [$clog2(CHANNELS)-1:0]   req_chan,
  input  logic [DATA_W-1:0]             req_value,
  input  logic [CHANNELS/2-1:0]         req_mask,
  input  logic [CNT_W-1:0]              cfg_wr_cyc,
  input  logic [CNT_W-1:0]              cfg_setup_cyc,
  input  logic [CNT_W-1:0]              cfg_ld_cyc,
  input  logic [CNT_W-1:0]              cfg_clr_cyc,
  output logic                          bus_cs_n,
  output logic                          bus_wr_n,
  output logic [$clog2(CHANNELS)-1:0]   bus_addr,
  output logic [DATA_W-1:0]             bus_data,
  output logic [CHANNELS/2-1:0]         bus_ld_n,
  output logic                          bus_clr_n
);
  import dacseq_pkg::*;

  localparam int CH_W  = $clog2(CHANNELS);
  localparam int PAIRS = CHANNELS / 2;
  localparam logic [DATA_W-1:0] HALF = DATA_W'(1) << (DATA_W - 1);

  seq_state_e        state_q;
  req_kind_e         kind_q;
  logic [PAIRS-1:0]  mask_q;
  logic              cs_n_q, wr_n_q, clr_n_q;
  logic [PAIRS-1:0]  ld_n_q;
  logic [CH_W-1:0]   addr_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] fmt_val;

  logic              tmr_start, tmr_zero;
  logic [CNT_W-1:0]  tmr_len, strobe_len, tail_len;

  dacseq_fmt #(.DW(DATA_W)) u_fmt (
    .twos_i (req_value),
    .offs_o (fmt_val)
  );

  dacseq_timer #(.CW(CNT_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .start_i (tmr_start),
    .len_i   (tmr_len),
    .zero_o  (tmr_zero)
  );

  // Strobe low time must cover both the write width and the data setup.
  assign strobe_len = (cfg_wr_cyc > cfg_setup_cyc) ? cfg_wr_cyc : cfg_setup_cyc;
  assign tail_len   = (kind_q == KIND_WRLD) ? cfg_ld_cyc : CNT_W'(1);

  always_comb begin
    tmr_start = 1'b0;
    tmr_len   = '0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          tmr_start = (req_kind == KIND_LOAD) || (req_kind == KIND_CLEAR);
          tmr_len   = (req_kind == KIND_CLEAR) ? cfg_clr_cyc : cfg_ld_cyc;
        end
      end
      ST_SETUP: begin
        tmr_start = 1'b1;
        tmr_len   = strobe_len;
      end
      ST_STROBE: begin
        tmr_start = tmr_zero;
        tmr_len   = tail_len;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      kind_q  <= KIND_WRITE;
      mask_q  <= '0;
      cs_n_q  <= 1'b1;
      wr_n_q  <= 1'b1;
      clr_n_q <= 1'b1;
      ld_n_q  <= '1;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            kind_q <= req_kind_e'(req_kind);
            mask_q <= req_mask;
            case (req_kind_e'(req_kind))
              KIND_LOAD: begin
                ld_n_q  <= ~req_mask;
                state_q <= ST_LOAD;
              end
              KIND_CLEAR: begin
                clr_n_q <= 1'b0;
                state_q <= ST_CLEAR;
              end
              default: begin
                addr_q  <= req_chan;
                data_q  <= fmt_val;
                state_q <= ST_SETUP;
              end
            endcase
          end
        end
        ST_SETUP: begin
          cs_n_q  <= 1'b0;
          wr_n_q  <= 1'b0;
          if (kind_q == KIND_WRLD) ld_n_q <= ~mask_q;
          state_q <= ST_STROBE;
        end
        ST_STROBE: begin
          if (tmr_zero) begin
            cs_n_q  <= 1'b1;
            wr_n_q  <= 1'b1;
            state_q <= ST_TAIL;
          end
        end
        ST_TAIL, ST_LOAD: begin
          if (tmr_zero) begin
            ld_n_q  <= '1;
            state_q <= ST_IDLE;
          end
        end
        ST_CLEAR: begin
          if (tmr_zero) begin
            clr_n_q <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign bus_cs_n  = cs_n_q;
  assign bus_wr_n  = wr_n_q;
  assign bus_clr_n = clr_n_q;
  assign bus_ld_n  = ld_n_q;
  assign bus_addr  = addr_q;
  assign bus_data  = data_q;

  assert_accept_drops_ready_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_busy_while_strobed_R2: assert property (@(posedge clk) disable iff (rst)
    (!bus_cs_n || !bus_clr_n || (bus_ld_n != '1)) |-> !req_ready);

  assert_setup_before_fall_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_wr_n) |-> ($stable(bus_addr) && $stable(bus_data)));

  assert_hold_after_rise_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_wr_n) |=> ($stable(bus_addr) && $stable(bus_data)));

  assert_cs_tracks_wr_R4: assert property (@(posedge clk) disable iff (rst)
    bus_cs_n == bus_wr_n);

  assert_offset_binary_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && (req_kind == KIND_WRITE))
      |=> (bus_data == DATA_W'($past(req_value) + HALF)));

  assert_load_outlasts_write_R7: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_wr_n) && (kind_q == KIND_WRLD) && (mask_q != '0)) |-> (bus_ld_n != '1));

  assert_clear_alone_R8: assert property (@(posedge clk) disable iff (rst)
    !bus_clr_n |-> (bus_wr_n && (bus_ld_n == '1)));
endmodule

// File: tb/dacseq_top_tb.sv
module dacseq_top_tb_top;
  localparam int PERIOD = 10;
  localparam logic [1:0] K_WR = 2'd0, K_LD = 2'd1, K_CLR = 2'd2, K_WL = 2'd3;

  typedef struct packed {
    logic [1:0]  kind;
    logic [2:0]  chan;
    logic [12:0] value;
    logic [3:0]  mask;
    logic [12:0] exp_data;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{K_WR,  3'd0, 13'h0000, 4'b0000, 13'h1000},
    '{K_WR,  3'd7, 13'h1FFF, 4'b0000, 13'h0FFF},
    '{K_WR,  3'd3, 13'h0FFF, 4'b0000, 13'h1FFF},
    '{K_WR,  3'd5, 13'h1000, 4'b0000, 13'h0000},
    '{K_LD,  3'd0, 13'h0000, 4'b0101, 13'h0000},
    '{K_LD,  3'd0, 13'h0000, 4'b1111, 13'h0000},
    '{K_CLR, 3'd0, 13'h0000, 4'b0000, 13'h0000},
    '{K_WL,  3'd2, 13'h0123, 4'b0010, 13'h1123},
    '{K_LD,  3'd0, 13'h0000, 4'b0000, 13'h0000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_kind = '0;
  logic [2:0] req_chan = '0;
  logic [12:0] req_value = '0;
  logic [3:0] req_mask = '0;
  logic [7:0] cfg_wr_cyc = 8'd3, cfg_setup_cyc = 8'd5, cfg_ld_cyc = 8'd2, cfg_clr_cyc = 8'd4;
  logic bus_cs_n, bus_wr_n, bus_clr_n;
  logic [2:0] bus_addr;
  logic [12:0] bus_data;
  logic [3:0] bus_ld_n;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  dacseq_top dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_chan(req_chan), .req_value(req_value), .req_mask(req_mask),
    .cfg_wr_cyc(cfg_wr_cyc), .cfg_setup_cyc(cfg_setup_cyc),
    .cfg_ld_cyc(cfg_ld_cyc), .cfg_clr_cyc(cfg_clr_cyc),
    .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_ld_n(bus_ld_n), .bus_clr_n(bus_clr_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int eff(input logic [7:0] x);
    return (x == 8'd0) ? 1 : int'(x);
  endfunction

  task automatic run_req(input vec_t v);
    int n, l, c, busy, wrlow, mism, bad, pre, holdbad, clrlow, exp_busy, exp_ld;
    int ldc [4];
    logic prev_wr;
    n = (eff(cfg_wr_cyc) > eff(cfg_setup_cyc)) ? eff(cfg_wr_cyc) : eff(cfg_setup_cyc);
    l = eff(cfg_ld_cyc);
    c = eff(cfg_clr_cyc);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_kind = v.kind; req_chan = v.chan;
    req_value = v.value; req_mask = v.mask;
    @(negedge clk);
    req_valid = 1'b0;
    busy = 0; wrlow = 0; mism = 0; bad = 0; pre = 0; holdbad = 0; clrlow = 0;
    for (int i = 0; i < 4; i++) ldc[i] = 0;
    prev_wr = 1'b1;
    while (!req_ready && busy < 1000) begin
      if (!bus_wr_n) wrlow++;
      if (bus_cs_n != bus_wr_n) mism++;
      if (!bus_wr_n && (bus_addr != v.chan || bus_data != v.exp_data)) bad++;
      if (bus_wr_n && wrlow == 0 && bus_addr == v.chan && bus_data == v.exp_data) pre++;
      if (!prev_wr && bus_wr_n && (bus_addr != v.chan || bus_data != v.exp_data)) holdbad++;
      if (!bus_clr_n) clrlow++;
      for (int i = 0; i < 4; i++) if (!bus_ld_n[i]) ldc[i]++;
      prev_wr = bus_wr_n;
      busy++;
      @(negedge clk);
    end
    case (v.kind)
      K_WR:    exp_busy = n + 2;
      K_LD:    exp_busy = l;
      K_CLR:   exp_busy = c;
      default: exp_busy = n + 1 + l;
    endcase
    chk(busy == exp_busy, "R2 busy cycles", busy, exp_busy);
    if (v.kind == K_WR || v.kind == K_WL) begin
      chk(wrlow == n, "R4 write low cycles", wrlow, n);
      chk(mism == 0, "R4 cs/wr mismatch", mism, 0);
      chk(pre >= 1, "R3 setup before fall", pre, 1);
      chk(bad == 0, "R5 addr/data during strobe", bad, 0);
      chk(holdbad == 0, "R3 hold after rise", holdbad, 0);
    end else begin
      chk(wrlow == 0, "R4 no write strobe", wrlow, 0);
    end
    chk(clrlow == ((v.kind == K_CLR) ? c : 0), "R8 clear low cycles", clrlow,
        (v.kind == K_CLR) ? c : 0);
    for (int i = 0; i < 4; i++) begin
      if (!v.mask[i]) exp_ld = 0;
      else if (v.kind == K_LD) exp_ld = l;
      else if (v.kind == K_WL) exp_ld = n + l;
      else exp_ld = 0;
      chk(ldc[i] == exp_ld, (v.kind == K_WL) ? "R7 load overlap cycles" : "R6 load low cycles",
          ldc[i], exp_ld);
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk(req_ready && bus_cs_n && bus_wr_n && bus_clr_n && bus_ld_n == 4'hF,
        "R1 reset state", int'({req_ready, bus_cs_n, bus_wr_n, bus_clr_n, bus_ld_n}), 255);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && bus_cs_n && bus_wr_n && bus_clr_n && bus_ld_n == 4'hF,
        "R1 after reset", int'({req_ready, bus_cs_n, bus_wr_n, bus_clr_n, bus_ld_n}), 255);

    for (int k = 0; k < NVEC; k++) run_req(VECS[k]);

    // R9: zero counts round up to one cycle
    cfg_wr_cyc = 8'd0; cfg_setup_cyc = 8'd0; cfg_ld_cyc = 8'd0; cfg_clr_cyc = 8'd0;
    run_req('{K_WR, 3'd6, 13'h1ABC, 4'b0000, 13'h0ABC});
    run_req('{K_WL, 3'd1, 13'h0001, 4'b1001, 13'h1001});
    run_req('{K_CLR, 3'd0, 13'h0000, 4'b0000, 13'h0000});

    // R4: write width larger than setup sets the strobe length
    cfg_wr_cyc = 8'd7; cfg_setup_cyc = 8'd2; cfg_ld_cyc = 8'd3; cfg_clr_cyc = 8'd1;
    run_req('{K_WL, 3'd4, 13'h1555, 4'b0100, 13'h0555});
    run_req('{K_LD, 3'd0, 13'h0000, 4'b1000, 13'h0000});

    @(negedge clk);
    chk(req_ready && bus_ld_n == 4'hF && bus_clr_n, "R2 idle after sequences",
        int'(req_ready), 1);

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule